// File: doc/BRIEF.md
# Debug Address Event Detector

This block watches a CPU bus and signals a debug event on an active-low pin whenever an access hits a programmed target address with a programmed access type. A debugger programs the detector through a small register port. One register holds the 32-bit target address. One holds a two-bit access condition that selects read, write, either, or a blocked setting. One holds a global enable. The fourth is a write-only trigger: any write to it fires an event without a bus match.

Instruction fetches count as reads. Under the read condition, a prefetch of the target address fires the event even if that instruction is later discarded. Each event produces a fixed two-cycle low pulse. Events that arrive close together are either absorbed into the running pulse or chained onto it. After any configuration write, hardware matching is held off for three clocks so that the new settings are in place before they are used.

Top module: `dbg_addr_event_det`

## Requirements
- R1: After reset `eventN` is high, and the condition (select 0), target (select 1) and enable (select 3) registers all read zero.
- R2: With condition code 00, a valid access to the target address that is a read or an instruction fetch fires an event. A write does not fire.
- R3: With condition code 01, only a valid write (not a fetch) to the target address fires an event.
- R4: With condition code 10, both reads (including fetches) and writes to the target address fire an event.
- R5: With condition code 11, no bus access fires an event. A write to the trigger register still fires one.
- R6: An event whose request is seen in cycle c drives `eventN` low in cycles c+1 and c+2 only, when no other event is pending.
- R7: A request in the first low cycle of a pulse is absorbed. A request in the last low cycle starts a new two-cycle pulse straight after it, so `eventN` stays low for four cycles.
- R8: A write to select 0, 1 or 3 suppresses bus-match events in the three cycles after the write. From the fourth cycle on, matching uses the new settings.
- R9: The condition register (select 0) keeps its code high bit at data bit 2 and its code low bit at data bit 1. All other bits read zero, and writes to them are ignored.
- R10: Any write to select 2 fires one event. Reads of select 2 return zero.
- R11: Bit 0 of select 3 enables bus matching. While it is 0, no bus access fires an event, but trigger writes still do.
- R12: A bus event needs `busValid` high and all 32 address bits equal to the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | An access is present on the bus this cycle |
| busWrite | input | 1 | The access is a write |
| busFetch | input | 1 | The access is an instruction fetch or prefetch |
| busAddr | input | 32 | Access address |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 condition, 1 target, 2 trigger, 3 enable |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data for the selected register |
| eventN | output | 1 | Active-low event pulse |

## Verification
The checker assumes that an instruction fetch is never flagged as a write, so `busFetch` and `busWrite` are never both high on a valid access. The assertions also treat the register port as a single-cycle strobe with no wait states. The random stimulus draws `busWrite` only when `busFetch` is low. It issues register writes as isolated one-cycle strobes that are interleaved with bus traffic, and it biases addresses toward the current target and its single-bit neighbours so that both matches and near misses occur.

// File: rtl/dae_pkg.sv
package dae_pkg;

  // Access condition codes held in the condition register
  typedef enum logic [1:0] {
    ACC_READ    = 2'b00,
    ACC_WRITE   = 2'b01,
    ACC_EITHER  = 2'b10,
    ACC_BLOCKED = 2'b11
  } accCond_t;

  // Register select encodings
  localparam logic [1:0] SEL_COND   = 2'd0;
  localparam logic [1:0] SEL_TARGET = 2'd1;
  localparam logic [1:0] SEL_TRIG   = 2'd2;
  localparam logic [1:0] SEL_ENABLE = 2'd3;

  // Field positions inside the register data word
  localparam int COND_HI_BIT = 2;
  localparam int COND_LO_BIT = 1;
  localparam int ENABLE_BIT  = 0;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadTarget;
    logic loadCond;
  } dpStrobe_t;

endpackage

// File: rtl/dae_datapath.sv
module dae_datapath
  import dae_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [1:0]        regSel,
  input  logic              enBit,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic              busFetch,
  input  logic [ADDR_W-1:0] busAddr,
  output logic              dpHit,
  output logic [DATA_W-1:0] regRdata
);

  localparam int NLANES = (ADDR_W + LANE_W - 1) / LANE_W;
  localparam int PAD_W  = NLANES * LANE_W;

  logic [ADDR_W-1:0] targetReg;
  accCond_t          condReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      targetReg <= '0;
      condReg   <= ACC_READ;
    end else begin
      if (strobe.loadTarget) targetReg <= regWdata[ADDR_W-1:0];
      if (strobe.loadCond)
        condReg <= accCond_t'({regWdata[COND_HI_BIT], regWdata[COND_LO_BIT]});
    end
  end

  // Lane-sliced address comparator
  logic [PAD_W-1:0]  addrPad;
  logic [PAD_W-1:0]  targetPad;
  logic [NLANES-1:0] laneEq;

  assign addrPad   = PAD_W'(busAddr);
  assign targetPad = PAD_W'(targetReg);

  for (genvar g = 0; g < NLANES; g++) begin : gLane
    assign laneEq[g] = (addrPad[g*LANE_W +: LANE_W] == targetPad[g*LANE_W +: LANE_W]);
  end

  logic addrEq;
  assign addrEq = &laneEq;

  // Access type qualification: a fetch counts as a read
  logic isRead;
  logic isWrite;
  logic condOk;

  assign isRead  = busFetch || !busWrite;
  assign isWrite = busWrite && !busFetch;

  always_comb begin
    unique case (condReg)
      ACC_READ:    condOk = isRead;
      ACC_WRITE:   condOk = isWrite;
      ACC_EITHER:  condOk = 1'b1;
      default:     condOk = 1'b0;
    endcase
  end

  assign dpHit = busValid && addrEq && condOk;

  // Register read mux
  always_comb begin
    regRdata = '0;
    unique case (regSel)
      SEL_COND: begin
        regRdata[COND_HI_BIT] = condReg[1];
        regRdata[COND_LO_BIT] = condReg[0];
      end
      SEL_TARGET: regRdata[ADDR_W-1:0] = targetReg;
      SEL_ENABLE: regRdata[ENABLE_BIT] = enBit;
      default:    regRdata = '0;
    endcase
  end

endmodule

// File: rtl/dae_ctrl.sv
module dae_ctrl
  import dae_pkg::*;
#(
  parameter int SETTLE_CYC = 3,
  parameter int PULSE_CYC  = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      regWe,
  input  logic [1:0] regSel,
  input  logic      enWdata,
  input  logic      dpHit,
  output dpStrobe_t strobe,
  output logic      enBit,
  output logic      eventN
);

  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam int PW = $clog2(PULSE_CYC + 1);

  logic          trigWr;
  logic          cfgWr;
  logic          enWr;
  logic [SW-1:0] settleCnt;
  logic [PW-1:0] pulseCnt;
  logic          armed;
  logic          evReq;

  assign trigWr = regWe && (regSel == SEL_TRIG);
  assign cfgWr  = regWe && (regSel != SEL_TRIG);
  assign enWr   = regWe && (regSel == SEL_ENABLE);

  always_comb begin
    strobe.loadTarget = regWe && (regSel == SEL_TARGET);
    strobe.loadCond   = regWe && (regSel == SEL_COND);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      enBit <= 1'b0;
    else if (enWr)  enBit <= enWdata;
  end

  // Settling window after any configuration write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                settleCnt <= '0;
    else if (cfgWr)           settleCnt <= SW'(SETTLE_CYC);
    else if (settleCnt != '0) settleCnt <= settleCnt - SW'(1);
  end

  assign armed = enBit && (settleCnt == '0);
  assign evReq = (armed && dpHit) || trigWr;

  // Pulse stretcher: absorb during early cycles, chain on the last one
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 pulseCnt <= '0;
    else if (pulseCnt > PW'(1)) pulseCnt <= pulseCnt - PW'(1);
    else if (evReq)            pulseCnt <= PW'(PULSE_CYC);
    else                       pulseCnt <= '0;
  end

  assign eventN = (pulseCnt == '0);

endmodule

// File: rtl/dbg_addr_event_det.sv
module dbg_addr_event_det
  import dae_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int SETTLE_CYC = 3,
  parameter int PULSE_CYC  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic              busFetch,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              eventN
);

  dpStrobe_t strobe;
  logic      dpHit;
  logic      enBit;

  dae_ctrl #(
    .SETTLE_CYC (SETTLE_CYC),
    .PULSE_CYC  (PULSE_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWe   (regWe),
    .regSel  (regSel),
    .enWdata (regWdata[ENABLE_BIT]),
    .dpHit   (dpHit),
    .strobe  (strobe),
    .enBit   (enBit),
    .eventN  (eventN)
  );

  dae_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .regWdata (regWdata),
    .regSel   (regSel),
    .enBit    (enBit),
    .busValid (busValid),
    .busWrite (busWrite),
    .busFetch (busFetch),
    .busAddr  (busAddr),
    .dpHit    (dpHit),
    .regRdata (regRdata)
  );

endmodule

// File: rtl/dae_checker.sv
module dae_checker (
  input logic        clk,
  input logic        rstN,
  input logic        busValid,
  input logic        busWrite,
  input logic        busFetch,
  input logic        regWe,
  input logic [1:0]  regSel,
  input logic [31:0] regRdata,
  input logic        eventN
);

  // R1
  always @(negedge clk) begin
    if (!rstN) reset_high_chk: assert (eventN);
  end

  // R10
  always @(negedge clk) begin
    if (rstN && regSel == 2'd2) trig_reads_zero_chk: assert (regRdata == 32'd0);
  end

  // R9
  always @(negedge clk) begin
    if (rstN && regSel == 2'd0)
      cond_reserved_zero_chk: assert (regRdata[31:3] == 29'd0 && regRdata[0] == 1'b0);
  end

  // R10
  trig_fires_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regSel == 2'd2) |=> !eventN);

  // R6
  pulse_min_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(eventN) |=> !eventN);

  // R2 (input rule: a fetch is never a write)
  fetch_is_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busFetch) |-> !busWrite);

endmodule

bind dbg_addr_event_det dae_checker u_dae_checker (
  .clk      (clk),
  .rstN     (rstN),
  .busValid (busValid),
  .busWrite (busWrite),
  .busFetch (busFetch),
  .regWe    (regWe),
  .regSel   (regSel),
  .regRdata (regRdata),
  .eventN   (eventN)
);

// File: tb/dbg_addr_event_det_bench.sv
module dbg_addr_event_det_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic        busFetch = 1'b0;
  logic [31:0] busAddr = '0;
  logic        regWe = 1'b0;
  logic [1:0]  regSel = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        eventN;

  int    total = 0;
  int    bad = 0;
  bit    finished = 0;
  string curTag = "R1";

  // Reference state, built from the requirements
  bit          mEn = 0;
  logic [31:0] mTarget = '0;
  logic [1:0]  mCond = 2'b00;
  int          mSettle = 0;
  int          mPulse = 0;

  always #4 clk = ~clk;

  dbg_addr_event_det u_dbg_addr_event_det (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busFetch(busFetch), .busAddr(busAddr), .regWe(regWe), .regSel(regSel),
    .regWdata(regWdata), .regRdata(regRdata), .eventN(eventN)
  );

  function automatic bit condMatch(logic [1:0] c, logic w, logic f);
    bit rd = f || !w;
    bit wr = w && !f;
    case (c)
      2'b00:   return rd;
      2'b01:   return wr;
      2'b10:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelStep();
    bit hit, trig;
    hit = busValid && mEn && (mSettle == 0) && (busAddr == mTarget)
          && condMatch(mCond, busWrite, busFetch);
    trig = regWe && (regSel == 2'd2);
    if (mPulse <= 1) mPulse = (hit || trig) ? 2 : 0;
    else mPulse = mPulse - 1;
    if (regWe && regSel != 2'd2) mSettle = 3;
    else if (mSettle > 0) mSettle = mSettle - 1;
    if (regWe) begin
      case (regSel)
        2'd0: mCond = {regWdata[2], regWdata[1]};
        2'd1: mTarget = regWdata;
        2'd3: mEn = regWdata[0];
        default: ;
      endcase
    end
  endtask

  task automatic cyc();
    modelStep();
    @(negedge clk);
    chk(curTag, {31'd0, eventN}, {31'd0, (mPulse == 0)});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] d);
    regWe = 1'b1; regSel = sel; regWdata = d;
    cyc();
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic acc(logic [31:0] a, logic w, logic f);
    busValid = 1'b1; busAddr = a; busWrite = w; busFetch = f;
    cyc();
    busValid = 1'b0; busWrite = 1'b0; busFetch = 1'b0;
  endtask

  task automatic rd(string tag, logic [1:0] sel, logic [31:0] exp);
    regSel = sel;
    #1;
    chk(tag, regRdata, exp);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  localparam logic [31:0] T1 = 32'h0000_4A10;
  localparam logic [31:0] T2 = 32'h8001_0C04;

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {31'd0, eventN}, 32'd1);
    rd("R1", 2'd0, 32'd0);
    rd("R1", 2'd1, 32'd0);
    rd("R1", 2'd3, 32'd0);
    rstN = 1'b1;
    idle(2);

    // R9 layout of the condition register
    curTag = "R9";
    wr(2'd0, 32'hFFFF_FFFD);
    rd("R9", 2'd0, 32'h0000_0004);
    wr(2'd0, 32'h0000_0000);
    rd("R9", 2'd0, 32'h0000_0000);
    rd("R10", 2'd2, 32'd0);

    wr(2'd1, T1);
    rd("R12", 2'd1, T1);
    wr(2'd3, 32'd1);
    rd("R11", 2'd3, 32'd1);
    idle(4);

    // R2 read condition: fetch, operand read, then write
    curTag = "R2";
    acc(T1, 1'b0, 1'b1); idle(3);
    acc(T1, 1'b0, 1'b0); idle(3);
    acc(T1, 1'b1, 1'b0); idle(3);

    // R12 address mismatch and invalid access
    curTag = "R12";
    acc(T1 ^ 32'h8000_0000, 1'b0, 1'b0); idle(2);
    acc(T1 ^ 32'h0000_0001, 1'b0, 1'b1); idle(2);
    busAddr = T1; busValid = 1'b0; cyc(); idle(2);

    // R3 write condition
    curTag = "R3";
    wr(2'd0, 32'h0000_0002); idle(4);
    acc(T1, 1'b0, 1'b0); idle(2);
    acc(T1, 1'b0, 1'b1); idle(2);
    acc(T1, 1'b1, 1'b0); idle(3);

    // R4 either
    curTag = "R4";
    wr(2'd0, 32'h0000_0004); idle(4);
    acc(T1, 1'b0, 1'b0); idle(3);
    acc(T1, 1'b1, 1'b0); idle(3);

    // R5 blocked code
    curTag = "R5";
    wr(2'd0, 32'h0000_0006); idle(4);
    acc(T1, 1'b0, 1'b0); idle(2);
    acc(T1, 1'b1, 1'b0); idle(2);
    acc(T1, 1'b0, 1'b1); idle(2);
    wr(2'd2, 32'h0000_005A); idle(3);

    // R6 single pulse width
    curTag = "R6";
    wr(2'd0, 32'h0000_0000); idle(4);
    acc(T1, 1'b0, 1'b0); idle(4);

    // R7 absorb in first low cycle, chain on the last
    curTag = "R7";
    busValid = 1'b1; busAddr = T1; busWrite = 1'b0; busFetch = 1'b0;
    cyc(); cyc();
    busValid = 1'b0; idle(3);
    acc(T1, 1'b0, 1'b0); cyc(); acc(T1, 1'b0, 1'b0); idle(5);
    wr(2'd2, 32'd0); wr(2'd2, 32'd0); wr(2'd2, 32'd0); idle(4);

    // R8 settling after changing the target
    curTag = "R8";
    wr(2'd1, T2);
    busValid = 1'b1; busAddr = T2;
    cyc(); cyc(); cyc(); cyc();
    busValid = 1'b0; idle(3);
    acc(T1, 1'b0, 1'b0); idle(3);

    // R11 enable gating
    curTag = "R11";
    wr(2'd3, 32'd0); idle(4);
    acc(T2, 1'b0, 1'b0); idle(2);
    wr(2'd2, 32'h1); idle(3);
    wr(2'd3, 32'd1); idle(4);

    // Mixed random traffic
    curTag = "R7";
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      busValid = r[0] | r[1];
      case (r[3:2])
        2'd0, 2'd1: busAddr = mTarget;
        2'd2:       busAddr = mTarget ^ (32'd1 << r[8:4]);
        default:    busAddr = $urandom;
      endcase
      busFetch = r[9];
      busWrite = r[10] && !r[9];
      regWe = (r[14:11] == 4'd0);
      regSel = r[16:15];
      case (r[16:15])
        2'd1:    regWdata = r[17] ? mTarget : (r[18] ? T1 : T2);
        2'd3:    regWdata = {31'd0, r[19] | r[20]};
        default: regWdata = $urandom;
      endcase
      cyc();
      regWe = 1'b0;
    end
    busValid = 1'b0;
    idle(4);
    summary();
  end

endmodule